// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave Interface

This block is the slave end of a byte-wide bus on which one set of wires carries first a register index and then data. It serves a 128-byte register file that holds timekeeping registers and general-purpose RAM. A static strap picks one of two timing styles. In strobe style, a data strobe frames the data phase and a read/write level gives its direction. In enable style, one line works as an active-low write enable and the data strobe works as an active-low output enable.

Every bus pin is brought into a fast system clock domain through a two-stage synchronizer, and all edges are found in that domain. The falling address strobe captures the register index. The rising address strobe discards it, and every data phase uses it up, so a fresh address strobe must come before each access. An accepted write gives the register file a single-cycle write enable with a 7-bit index and 8-bit data. An accepted read gives a single-cycle read enable, and the returned byte is then driven onto the bus through a tri-state output enable. A power-fail input masks chip select inside the block, and it also forces the output enable off at once.

Top module: `muxbus_slave`

## Requirements
- R1: The falling edge of the address strobe captures bus bits 6..0 as the register index. Bit 7 of the address byte has no effect on which register is reached.
- R2: A rising edge of the address strobe discards the captured index whether or not chip select is active. A data phase that follows it with no new falling edge performs no access.
- R3: With the strap high, a data phase with the read/write line low while the data strobe is high is a write. The byte on the bus is captured at the trailing edge of the data strobe and produces exactly one write-enable pulse.
- R4: With the strap high, a data phase with the read/write line high while the data strobe is high is a read. It produces one read-enable pulse, and the addressed byte is driven only while the data strobe stays high.
- R5: With the strap low, the read/write line is an active-low write enable. Data is captured on its rising edge and produces exactly one write-enable pulse.
- R6: With the strap low, the data strobe low with the write enable high is a read. It produces one read-enable pulse, and the addressed byte is driven only while the data strobe stays low.
- R7: A data phase with chip select (active low) inactive makes no access and still uses up the captured index. The next selected access needs a new address strobe.
- R8: A write during which chip select goes inactive for part of the data phase is dropped.
- R9: While power-fail is high, no write or read enable is issued and the bus output enable is low.
- R10: While reset is low, the output enable and both register strobes are low.
- R11: The write enable and read enable are never high in the same cycle. Each is high for exactly one cycle per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busMode | input | 1 | Timing strap: 1 strobe style, 0 enable style |
| powerFail | input | 1 | High blocks all access |
| csN | input | 1 | Active-low chip select |
| addrStb | input | 1 | Address strobe, index captured on falling edge |
| dataStb | input | 1 | Data strobe (strobe style) or active-low output enable (enable style) |
| rwLine | input | 1 | Read/write level (strobe style) or active-low write enable (enable style) |
| adBusIn | input | 8 | Multiplexed bus, input side |
| adBusOut | output | 8 | Read data for the bus pads |
| adBusOe | output | 1 | Tri-state enable for the bus pads |
| regAddr | output | 7 | Register index toward the register file |
| regWrData | output | 8 | Write data toward the register file |
| regWrEn | output | 1 | Single-cycle write strobe |
| regRdEn | output | 1 | Single-cycle read strobe |
| regRdData | input | 8 | Byte returned by the register file at regAddr |

## Verification
Each timing style runs a full sweep: all 128 indices are written with an arithmetic pattern and then read back. Odd indices are written with bit 7 of the address byte set, which shows whether that bit leaks into the decode. Pulse counts are compared against the number of accesses to catch missing or doubled strobes. After the sweeps, targeted cycles separate the cases that must make no change from those that must: deselected phases, phases with no new strobe, a strobe still high, chip select dropped mid-write, and power fail. Each of these is followed by a read through the bus, or a look at the modelled register file, that shows whether anything changed.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef struct packed {
    logic addrLoad;
    logic addrClear;
    logic wrFire;
    logic rdCapture;
  } busStrobes_t;
endpackage

// File: rtl/muxbus_sync.sv
module muxbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= RST_VAL;
    else       stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[g] <= RST_VAL;
      else       stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busMode,
  input  logic        sPf,
  input  logic        sCsN,
  input  logic        sAs,
  input  logic        sDs,
  input  logic        sRw,
  output busStrobes_t stb,
  output logic        regWrEn,
  output logic        regRdEn,
  output logic        driveOn
);
  logic asPrev, dsPrev, rwPrev;
  logic addrValid, csOk;
  logic csEff, winNow, winPrev, winStart, winEnd;
  logic rdStart, wrEdge, readCond, rdFire, wrFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asPrev <= 1'b0;
      dsPrev <= 1'b1;
      rwPrev <= 1'b1;
    end else begin
      asPrev <= sAs;
      dsPrev <= sDs;
      rwPrev <= sRw;
    end
  end

  always_comb begin
    csEff    = !sCsN && !sPf;
    winNow   = busMode ? sDs    : (!sDs || !sRw);
    winPrev  = busMode ? dsPrev : (!dsPrev || !rwPrev);
    winStart = winNow && !winPrev;
    winEnd   = !winNow && winPrev;
    rdStart  = busMode ? (winStart && sRw) : (dsPrev && !sDs && sRw);
    wrEdge   = busMode ? (winEnd && !rwPrev) : (!rwPrev && sRw);
    readCond = busMode ? (sDs && sRw) : (!sDs && sRw);
    rdFire   = rdStart && csEff && addrValid && (winStart || csOk);
    wrFire   = wrEdge && csOk && !sPf && addrValid;
    stb.addrLoad  = asPrev && !sAs;
    stb.addrClear = !asPrev && sAs;
    stb.wrFire    = wrFire;
    stb.rdCapture = regRdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      csOk      <= 1'b0;
      regWrEn   <= 1'b0;
      regRdEn   <= 1'b0;
      driveOn   <= 1'b0;
    end else begin
      if (stb.addrClear)     addrValid <= 1'b0;
      else if (stb.addrLoad) addrValid <= 1'b1;
      else if (winEnd)       addrValid <= 1'b0;

      if (winStart)    csOk <= csEff;
      else if (winNow) csOk <= csOk && csEff;

      regWrEn <= wrFire;
      regRdEn <= rdFire;

      if (regRdEn) driveOn <= 1'b1;
      else         driveOn <= driveOn && readCond && csEff;
    end
  end
endmodule

// File: rtl/muxbus_dp.sv
module muxbus_dp
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       stb,
  input  logic [DATA_W-1:0] sAd,
  input  logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] rdHold
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddr   <= '0;
      regWrData <= '0;
      rdHold    <= '0;
    end else begin
      if (stb.addrClear)     regAddr <= '0;
      else if (stb.addrLoad) regAddr <= sAd[ADDR_W-1:0];
      if (stb.wrFire)    regWrData <= sAd;
      if (stb.rdCapture) rdHold    <= regRdData;
    end
  end
endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode,
  input  logic              powerFail,
  input  logic              csN,
  input  logic              addrStb,
  input  logic              dataStb,
  input  logic              rwLine,
  input  logic [DATA_W-1:0] adBusIn,
  output logic [DATA_W-1:0] adBusOut,
  output logic              adBusOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData
);
  localparam int CTL_W = 5;
  localparam logic [CTL_W-1:0] CTL_RST = 5'b11011;

  logic [CTL_W-1:0] ctlSync;
  logic [DATA_W-1:0] sAd;
  logic driveOn;
  busStrobes_t stb;

  muxbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) uCtlSync (
    .clk(clk), .rstN(rstN),
    .din({powerFail, csN, addrStb, dataStb, rwLine}),
    .dout(ctlSync)
  );

  muxbus_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) uBusSync (
    .clk(clk), .rstN(rstN), .din(adBusIn), .dout(sAd)
  );

  muxbus_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busMode(busMode),
    .sPf(ctlSync[4]), .sCsN(ctlSync[3]), .sAs(ctlSync[2]),
    .sDs(ctlSync[1]), .sRw(ctlSync[0]),
    .stb(stb), .regWrEn(regWrEn), .regRdEn(regRdEn), .driveOn(driveOn)
  );

  muxbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sAd(sAd), .regRdData(regRdData),
    .regAddr(regAddr), .regWrData(regWrData), .rdHold(adBusOut)
  );

  assign adBusOe = driveOn && !powerFail;
endmodule

// File: rtl/muxbus_chk.sv
module muxbus_chk (
  input logic clk,
  input logic rstN,
  input logic powerFail,
  input logic regWrEn,
  input logic regRdEn,
  input logic adBusOe
);
  a_r11_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);
  a_r11_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));
  a_r9_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |-> !adBusOe);
  a_r9_no_strobes: assert property (@(posedge clk) disable iff (!rstN)
    $past(powerFail, 3) |-> (!regWrEn && !regRdEn));
  a_r4_drive_after_read: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(adBusOe) && !$past(powerFail)) |-> $past(regRdEn));
endmodule

bind muxbus_slave muxbus_chk uChk (
  .clk(clk), .rstN(rstN), .powerFail(powerFail),
  .regWrEn(regWrEn), .regRdEn(regRdEn), .adBusOe(adBusOe)
);

// File: tb/tb_muxbus_slave.sv
module tb_muxbus_slave;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, busMode, powerFail, csN, addrStb, dataStb, rwLine;
  logic [7:0] adBusIn, adBusOut, regWrData, regRdData;
  logic [6:0] regAddr;
  logic       adBusOe, regWrEn, regRdEn;
  logic [7:0] mem [128];

  int nCmp = 0, nBad = 0, wrCnt = 0, rdCnt = 0, overlap = 0, longPulse = 0;
  logic wrQ = 1'b0, rdQ = 1'b0;

  muxbus_slave dut (
    .clk(clk), .rstN(rstN), .busMode(busMode), .powerFail(powerFail),
    .csN(csN), .addrStb(addrStb), .dataStb(dataStb), .rwLine(rwLine),
    .adBusIn(adBusIn), .adBusOut(adBusOut), .adBusOe(adBusOe),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regRdData(regRdData)
  );

  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    if (rstN) begin
      if (regWrEn) begin mem[regAddr] <= regWrData; wrCnt++; end
      if (regRdEn) rdCnt++;
      if (regWrEn && regRdEn) overlap++;
      if ((regWrEn && wrQ) || (regRdEn && rdQ)) longPulse++;
    end
    wrQ <= regWrEn;
    rdQ <= regRdEn;
  end

  task automatic chk(input string req, input int act, input int exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int m);
    return 8'((a * 29 + 7 + m * 101) ^ (a << 3));
  endfunction

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addrPhase(input logic [7:0] a);
    addrStb = 1'b1; adBusIn = a; stepN(5);
    addrStb = 1'b0; stepN(5);
  endtask

  task automatic wrData(input logic [7:0] d, input bit sel, input bit drop);
    adBusIn = d; csN = !sel;
    if (busMode) begin
      rwLine = 1'b0; stepN(2); dataStb = 1'b1; stepN(4);
      if (drop) begin csN = 1'b1; stepN(4); csN = !sel; stepN(2); end
      dataStb = 1'b0; stepN(5); rwLine = 1'b1;
    end else begin
      stepN(2); rwLine = 1'b0; stepN(4);
      if (drop) begin csN = 1'b1; stepN(4); csN = !sel; stepN(2); end
      rwLine = 1'b1; stepN(5);
    end
    csN = 1'b1; stepN(2);
  endtask

  task automatic rdData(input bit sel, output logic [7:0] v, output logic oe,
                        output logic oeAfter);
    csN = !sel; stepN(2);
    if (busMode) begin rwLine = 1'b1; dataStb = 1'b1; end
    else dataStb = 1'b0;
    stepN(6);
    v = adBusOut; oe = adBusOe;
    dataStb = busMode ? 1'b0 : 1'b1;
    stepN(6);
    oeAfter = adBusOe;
    csN = 1'b1; stepN(2);
  endtask

  task automatic setMode(input bit m);
    rstN = 1'b0; busMode = m; dataStb = !m; rwLine = 1'b1; csN = 1'b1;
    addrStb = 1'b0; powerFail = 1'b0; adBusIn = 8'h00;
    stepN(4);
    chk("R10 oe in reset", adBusOe, 0);
    chk("R10 wr strobe in reset", regWrEn, 0);
    chk("R10 rd strobe in reset", regRdEn, 0);
    rstN = 1'b1; stepN(4);
    chk("R10 oe after reset", adBusOe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v, nv;
    logic oe, oeA;
    int c0, r0;
    for (int m = 0; m < 2; m++) begin
      setMode(m[0]);
      // R1/R3/R5 sweep: odd indices carry bit 7 set in the address byte
      c0 = wrCnt;
      for (int a = 0; a < 128; a++) begin
        addrPhase(8'(a) | ((a % 2 == 1) ? 8'h80 : 8'h00));
        wrData(pat(a, m), 1'b1, 1'b0);
      end
      chk(m ? "R3 write pulses" : "R5 write pulses", wrCnt - c0, 128);
      // R4/R6 read-back sweep
      r0 = rdCnt;
      for (int a = 0; a < 128; a++) begin
        addrPhase(8'(a));
        rdData(1'b1, v, oe, oeA);
        chk(m ? "R4/R1 read data" : "R6/R1 read data", v, pat(a, m));
        chk(m ? "R4 oe in window" : "R6 oe in window", oe, 1);
        chk(m ? "R4 oe after window" : "R6 oe after window", oeA, 0);
      end
      chk(m ? "R4 read pulses" : "R6 read pulses", rdCnt - r0, 128);

      // R7 deselected write, then reuse without strobe
      nv = 8'h5A ^ 8'(m);
      c0 = wrCnt;
      addrPhase(8'd5); wrData(nv, 1'b0, 1'b0);
      chk("R7 deselected write", mem[5], pat(5, m));
      wrData(nv, 1'b1, 1'b0);
      chk("R7 index used up", mem[5], pat(5, m));
      chk("R7 no write pulses", wrCnt - c0, 0);
      r0 = rdCnt;
      addrPhase(8'd5); rdData(1'b0, v, oe, oeA);
      chk("R7 deselected read oe", oe, 0);
      chk("R7 deselected read pulses", rdCnt - r0, 0);
      addrPhase(8'd5); wrData(nv, 1'b1, 1'b0);
      chk("R7 fresh strobe write", mem[5], nv);

      // R2 rising address strobe discards the index
      addrPhase(8'd9);
      addrStb = 1'b1; stepN(5);
      wrData(8'hC3, 1'b1, 1'b0);
      chk("R2 cleared index", mem[9], pat(9, m));
      adBusIn = 8'd9; stepN(2); addrStb = 1'b0; stepN(5);

      // R8 chip select dropped mid-write
      addrPhase(8'd12); wrData(8'h3C, 1'b1, 1'b1);
      chk("R8 dropped write", mem[12], pat(12, m));

      // R9 power fail
      powerFail = 1'b1; stepN(4);
      c0 = wrCnt; r0 = rdCnt;
      addrPhase(8'd20); wrData(8'h99, 1'b1, 1'b0);
      chk("R9 write blocked", mem[20], pat(20, m));
      addrPhase(8'd20); rdData(1'b1, v, oe, oeA);
      chk("R9 oe blocked", oe, 0);
      chk("R9 strobes blocked", (wrCnt - c0) + (rdCnt - r0), 0);
      powerFail = 1'b0; stepN(4);
      addrPhase(8'd20); rdData(1'b1, v, oe, oeA);
      chk("R9 recovery read", v, pat(20, m));

      chk("R11 overlap", overlap, 0);
      chk("R11 pulse width", longPulse, 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule